// File: doc/BRIEF.md
# Multichannel Burst Pulse Generator

This block drives a set of independent timing outputs. Each channel waits for a rising edge on the trigger input it is assigned to. It counts out a programmable delay and then issues a burst of pulses. Each pulse has a programmable width, consecutive pulses start a programmable period apart, and the number of pulses in the burst is programmable. All counting runs on an internal tick that is derived from the system clock. A control bit chooses between a fast tick and a slow tick, which are nominally 1 MHz and 100 kHz.

Software reaches the per-channel parameter sets through a small 16-bit register window. A channel-select register points at one channel. The parameter registers behind that pointer then read and write only that channel's set. Each 32-bit quantity (delay, width, period) occupies a low half and a high half. A global inhibit input blocks the start of new bursts. Bursts that are already running continue.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset every output is low and every register reads zero: control, channel select, and every parameter of channel 0.
- R2: Address 1 holds the channel select in bits [2:0], where code k selects channel k (outputs numbered from 0). Addresses 2 to 9 read and write only the selected channel's parameters, and the other channels keep their values.
- R3: Delay (addresses 2/3), width (4/5) and period (6/7) are 32-bit values. The lower address holds bits [15:0] and the higher address holds bits [31:16]. Address 8 holds the pulse count and address 9 holds the trigger-source index in bits [1:0]. Address 0 bit 2 is the rate bit, and all other control bits read 0.
- R4: With the rate bit at 0 a tick occurs every FAST_DIV clocks. With the rate bit at 1 a tick occurs every SLOW_DIV clocks. A pulse of width W lasts W ticks.
- R5: A rising edge on the selected trigger input starts an idle channel. With delay D, the first pulse rises on tick D+1 after the trigger, so delay 0 means the first tick.
- R6: The output stays high for W ticks from each pulse start, and a width of 0 gives no pulse at all. When the period is not larger than W, the output stays high for the whole burst.
- R7: Pulse k of a burst starts P ticks after pulse k-1. The burst holds N pulses, and N = 0 behaves as N = 1. A period of 0 behaves as a period of 1.
- R8: A trigger edge that arrives while the channel's sequence (delay or burst) is running is ignored.
- R9: Trigger edges that arrive while the inhibit input is high are ignored.
- R10: All channels run at the same time without affecting one another, including channels that share one trigger source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | HALF_W | Write data |
| regRdData | output | HALF_W | Read data for regAddr (combinational) |
| trigIn | input | NUM_SRC | Trigger sources, rising edge active |
| inhibit | input | 1 | Blocks new bursts while high |
| pulseOut | output | NUM_CH | One delayed pulse output per channel |

## Verification
Each channel's delay and phase share a single counter. A counter that advances on the wrong clock, or that misses a restart, moves the output's first edge by at least one full tick (FAST_DIV clocks) within the first pulse. A remaining-pulse count that reloads on a retrigger, or that mishandles the zero case, shows up as an extra or missing pulse within one period of the burst's expected end. The bench keeps an arithmetic model of each channel's expected output, indexed by tick count since the trigger, and compares all outputs on every clock. This exposes a wrong state within one tick of its occurrence.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DELAY = 2'd1,
    CH_RUN   = 2'd2
  } chState_t;

  // one strobe per parameter half, raised by the control for a single clock
  typedef struct packed {
    logic dlyLo;
    logic dlyHi;
    logic widLo;
    logic widHi;
    logic perLo;
    logic perHi;
    logic rep;
    logic tsel;
  } cfgStrobe_t;

  localparam logic [3:0] ADDR_CTRL   = 4'd0;
  localparam logic [3:0] ADDR_CHSEL  = 4'd1;
  localparam logic [3:0] ADDR_DLY_LO = 4'd2;
  localparam logic [3:0] ADDR_DLY_HI = 4'd3;
  localparam logic [3:0] ADDR_WID_LO = 4'd4;
  localparam logic [3:0] ADDR_WID_HI = 4'd5;
  localparam logic [3:0] ADDR_PER_LO = 4'd6;
  localparam logic [3:0] ADDR_PER_HI = 4'd7;
  localparam logic [3:0] ADDR_REP    = 4'd8;
  localparam logic [3:0] ADDR_TSEL   = 4'd9;

  localparam int RATE_BIT = 2;

endpackage

// File: rtl/pbg_ctrl.sv
module pbg_ctrl
  import pbg_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_SRC  = 4,
  parameter int FAST_DIV = 100,
  parameter int SLOW_DIV = 1000,
  localparam int SEL_W   = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [3:0]         regAddr,
  input  logic               wrRateBit,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [NUM_SRC-1:0] trigIn,
  output cfgStrobe_t         strb,
  output logic [SEL_W-1:0]   chSel,
  output logic               slowRate,
  output logic               tick,
  output logic [NUM_SRC-1:0] trigRise
);

  localparam int DIV_W = $clog2(SLOW_DIV);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divLim;
  logic [NUM_SRC-1:0] trigPrev;

  // bus decode into per-field strobes
  always_comb begin
    strb       = '0;
    strb.dlyLo = regWr && (regAddr == ADDR_DLY_LO);
    strb.dlyHi = regWr && (regAddr == ADDR_DLY_HI);
    strb.widLo = regWr && (regAddr == ADDR_WID_LO);
    strb.widHi = regWr && (regAddr == ADDR_WID_HI);
    strb.perLo = regWr && (regAddr == ADDR_PER_LO);
    strb.perHi = regWr && (regAddr == ADDR_PER_HI);
    strb.rep   = regWr && (regAddr == ADDR_REP);
    strb.tsel  = regWr && (regAddr == ADDR_TSEL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowRate <= 1'b0;
      chSel    <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_CTRL)  slowRate <= wrRateBit;
      if (regAddr == ADDR_CHSEL) chSel    <= wrSel;
    end
  end

  // tick divider; a limit drop mid-count wraps at once
  assign divLim = slowRate ? SLOW_LIM : FAST_LIM;
  assign tick   = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // trigger edge detection shared by all channels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= '0;
    else trigPrev <= trigIn;
  end

  assign trigRise = trigIn & ~trigPrev;

  p_tick_gap_r4 : assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_riseChk
    p_rise_single_r5 : assert property (@(posedge clk) disable iff (!rstN)
      trigRise[s] |=> !trigRise[s]);
  end

endmodule

// File: rtl/pbg_datapath.sv
module pbg_datapath
  import pbg_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SRC = 4,
  parameter int HALF_W  = 16,
  parameter int REP_W   = 16,
  localparam int CNT_W  = 2 * HALF_W,
  localparam int SEL_W  = $clog2(NUM_CH),
  localparam int TSEL_W = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strb,
  input  logic [SEL_W-1:0]               chSel,
  input  logic                           slowRate,
  input  logic [3:0]                     regAddr,
  input  logic [HALF_W-1:0]              wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0]   dlyAll,
  output logic [NUM_CH-1:0][CNT_W-1:0]   widAll,
  output logic [NUM_CH-1:0][CNT_W-1:0]   perAll,
  output logic [NUM_CH-1:0][REP_W-1:0]   repAll,
  output logic [NUM_CH-1:0][TSEL_W-1:0]  tselAll,
  output logic [HALF_W-1:0]              rdData
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_store
    logic hit;
    assign hit = (chSel == SEL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyAll[c]  <= '0;
        widAll[c]  <= '0;
        perAll[c]  <= '0;
        repAll[c]  <= '0;
        tselAll[c] <= '0;
      end else if (hit) begin
        if (strb.dlyLo) dlyAll[c][HALF_W-1:0]     <= wrData;
        if (strb.dlyHi) dlyAll[c][CNT_W-1:HALF_W] <= wrData;
        if (strb.widLo) widAll[c][HALF_W-1:0]     <= wrData;
        if (strb.widHi) widAll[c][CNT_W-1:HALF_W] <= wrData;
        if (strb.perLo) perAll[c][HALF_W-1:0]     <= wrData;
        if (strb.perHi) perAll[c][CNT_W-1:HALF_W] <= wrData;
        if (strb.rep)   repAll[c]                 <= wrData[REP_W-1:0];
        if (strb.tsel)  tselAll[c]                <= wrData[TSEL_W-1:0];
      end
    end
  end

  // indirect read port through the channel pointer
  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_CTRL:   rdData[RATE_BIT]  = slowRate;
      ADDR_CHSEL:  rdData[SEL_W-1:0] = chSel;
      ADDR_DLY_LO: rdData = dlyAll[chSel][HALF_W-1:0];
      ADDR_DLY_HI: rdData = dlyAll[chSel][CNT_W-1:HALF_W];
      ADDR_WID_LO: rdData = widAll[chSel][HALF_W-1:0];
      ADDR_WID_HI: rdData = widAll[chSel][CNT_W-1:HALF_W];
      ADDR_PER_LO: rdData = perAll[chSel][HALF_W-1:0];
      ADDR_PER_HI: rdData = perAll[chSel][CNT_W-1:HALF_W];
      ADDR_REP:    rdData = HALF_W'(repAll[chSel]);
      ADDR_TSEL:   rdData = HALF_W'(tselAll[chSel]);
      default:     rdData = '0;
    endcase
  end

  p_one_strobe_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  p_rep_lands_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.rep && regAddr == ADDR_REP) |=> (regAddr != ADDR_REP) || $changed(chSel)
      || (rdData == HALF_W'($past(wrData[REP_W-1:0]))));

endmodule

// File: rtl/pbg_channel.sv
module pbg_channel
  import pbg_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int REP_W   = 16,
  parameter int NUM_SRC = 4,
  localparam int TSEL_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [NUM_SRC-1:0] trigRise,
  input  logic               inhibit,
  input  logic [CNT_W-1:0]   dly,
  input  logic [CNT_W-1:0]   wid,
  input  logic [CNT_W-1:0]   per,
  input  logic [REP_W-1:0]   rep,
  input  logic [TSEL_W-1:0]  tsel,
  output logic               pulse
);

  chState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntInc;
  logic [REP_W-1:0] left;
  logic             start;
  logic             periodEnd;

  assign start     = (state == CH_IDLE) && trigRise[tsel] && !inhibit;
  assign cntInc    = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign periodEnd = (cntInc >= {1'b0, per});

  // cnt counts delay ticks in CH_DELAY and the pulse phase in CH_RUN
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CH_IDLE;
      cnt   <= '0;
      left  <= '0;
    end else begin
      case (state)
        CH_IDLE: begin
          if (start) begin
            state <= CH_DELAY;
            cnt   <= '0;
            left  <= (rep == '0) ? REP_W'(1) : rep;
          end
        end
        CH_DELAY: begin
          if (tick) begin
            if (cnt >= dly) begin
              state <= CH_RUN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        CH_RUN: begin
          if (tick) begin
            if (periodEnd) begin
              cnt <= '0;
              if (left <= REP_W'(1)) begin
                state <= CH_IDLE;
                left  <= '0;
              end else begin
                left <= left - 1'b1;
              end
            end else begin
              cnt <= cntInc[CNT_W-1:0];
            end
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  assign pulse = (state == CH_RUN) && (cnt < wid);

  p_hold_off_tick_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (state != CH_IDLE && !tick) |=> ($stable(cnt) && $stable(state)));

  p_no_reload_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (state != CH_IDLE && !tick) |=> $stable(left));

  p_inhibit_hold_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_IDLE && inhibit) |=> (state == CH_IDLE));

  p_count_min_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (state != CH_IDLE) |-> (left != '0));

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
  import pbg_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_SRC  = 4,
  parameter int HALF_W   = 16,
  parameter int REP_W    = 16,
  parameter int FAST_DIV = 100,
  parameter int SLOW_DIV = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [3:0]         regAddr,
  input  logic [HALF_W-1:0]  regWrData,
  output logic [HALF_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               inhibit,
  output logic [NUM_CH-1:0]  pulseOut
);

  localparam int CNT_W  = 2 * HALF_W;
  localparam int SEL_W  = $clog2(NUM_CH);
  localparam int TSEL_W = $clog2(NUM_SRC);

  cfgStrobe_t                    strb;
  logic [SEL_W-1:0]              chSel;
  logic                          slowRate;
  logic                          tick;
  logic [NUM_SRC-1:0]            trigRise;
  logic [NUM_CH-1:0][CNT_W-1:0]  dlyAll;
  logic [NUM_CH-1:0][CNT_W-1:0]  widAll;
  logic [NUM_CH-1:0][CNT_W-1:0]  perAll;
  logic [NUM_CH-1:0][REP_W-1:0]  repAll;
  logic [NUM_CH-1:0][TSEL_W-1:0] tselAll;

  pbg_ctrl #(
    .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC),
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wrRateBit(regWrData[RATE_BIT]), .wrSel(regWrData[SEL_W-1:0]),
    .trigIn(trigIn), .strb(strb), .chSel(chSel), .slowRate(slowRate),
    .tick(tick), .trigRise(trigRise)
  );

  pbg_datapath #(
    .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .HALF_W(HALF_W), .REP_W(REP_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .chSel(chSel), .slowRate(slowRate),
    .regAddr(regAddr), .wrData(regWrData), .dlyAll(dlyAll), .widAll(widAll),
    .perAll(perAll), .repAll(repAll), .tselAll(tselAll), .rdData(regRdData)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pbg_channel #(
      .CNT_W(CNT_W), .REP_W(REP_W), .NUM_SRC(NUM_SRC)
    ) u_chan (
      .clk(clk), .rstN(rstN), .tick(tick), .trigRise(trigRise),
      .inhibit(inhibit), .dly(dlyAll[g]), .wid(widAll[g]), .per(perAll[g]),
      .rep(repAll[g]), .tsel(tselAll[g]), .pulse(pulseOut[g])
    );
  end

endmodule

// File: tb/test_pulse_burst_gen.sv
module test_pulse_burst_gen;

  localparam int NCH  = 8;
  localparam int NSRC = 4;
  localparam int FDIV = 4;
  localparam int SDIV = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rstN = 1'b0;
  logic            regWr = 1'b0;
  logic [3:0]      regAddr = '0;
  logic [15:0]     regWrData = '0;
  logic [15:0]     regRdData;
  logic [NSRC-1:0] trigIn = '0;
  logic            inhibit = 1'b0;
  logic [NCH-1:0]  pulseOut;

  pulse_burst_gen #(
    .NUM_CH(NCH), .NUM_SRC(NSRC), .HALF_W(16), .REP_W(16),
    .FAST_DIV(FDIV), .SLOW_DIV(SDIV)
  ) i_pulse_burst_gen (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trigIn(trigIn),
    .inhibit(inhibit), .pulseOut(pulseOut)
  );

  int nRun = 0;
  int nFail = 0;

  // bench reference model (fast rate only)
  int unsigned edgeCnt, tc, tcb;
  bit          active [NCH];
  int unsigned trigTick [NCH];
  int          bd [NCH], bw [NCH], bp [NCH], bn [NCH], bs [NCH];
  logic [NSRC-1:0] prevTrig;
  bit          modelOn = 1'b0;

  function automatic int unsigned endT(int c);
    int nn, pp;
    nn = (bn[c] == 0) ? 1 : bn[c];
    pp = (bp[c] == 0) ? 1 : bp[c];
    return bd[c] + 1 + nn * pp;
  endfunction

  function automatic bit expOut(int c);
    int unsigned k, j;
    int nn;
    if (!active[c]) return 1'b0;
    k = tc - trigTick[c];
    if (k < bd[c] + 1) return 1'b0;
    j  = k - bd[c] - 1;
    nn = (bn[c] == 0) ? 1 : bn[c];
    if (bp[c] == 0) return (j < nn) && (bw[c] > 0);
    return ((j / bp[c]) < nn) && ((j % bp[c]) < bw[c]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      edgeCnt = 0; tc = 0; prevTrig = '0;
      for (int c = 0; c < NCH; c++) active[c] = 1'b0;
    end else begin
      tcb = tc;
      edgeCnt++;
      if (edgeCnt % FDIV == 0) tc++;
      for (int c = 0; c < NCH; c++) begin
        if (trigIn[bs[c]] && !prevTrig[bs[c]] && !inhibit &&
            !(active[c] && (tcb - trigTick[c]) < endT(c))) begin
          active[c]   = 1'b1;
          trigTick[c] = tc;
        end
      end
      prevTrig = trigIn;
    end
  end

  // every-cycle comparison of all outputs (R5 R6 R7 R8 R9 R10)
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      logic [NCH-1:0] e;
      for (int c = 0; c < NCH; c++) e[c] = expOut(c);
      nRun++;
      if (pulseOut !== e) begin
        nFail++;
        $display("FAIL R5 R6 R7 R8 R10 outputs at tick %0d: got %b exp %b", tc, pulseOut, e);
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; trigIn = '0; inhibit = 1'b0; regWr = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      bd[c] = 0; bw[c] = 0; bp[c] = 0; bn[c] = 0; bs[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regWr = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cfgCh(int c, int d, int w, int p, int n, int s);
    active[c] = 1'b0;
    bd[c] = d; bw[c] = w; bp[c] = p; bn[c] = n; bs[c] = s;
    wr(4'd1, 16'(c));
    wr(4'd2, 16'(d)); wr(4'd3, 16'(d >> 16));
    wr(4'd4, 16'(w)); wr(4'd5, 16'(w >> 16));
    wr(4'd6, 16'(p)); wr(4'd7, 16'(p >> 16));
    wr(4'd8, 16'(n)); wr(4'd9, 16'(s));
  endtask

  task automatic fire(logic [NSRC-1:0] m);
    @(negedge clk); trigIn = trigIn | m;
    @(negedge clk); trigIn = trigIn & ~m;
  endtask

  // count rises on one output and time its first edges
  task automatic measure(int ch, int cycles, output int rises, output int hiLen, output int riseGap);
    int t, r1, f1, r2;
    logic prev;
    rises = 0; r1 = -1; f1 = -1; r2 = -1; prev = pulseOut[ch];
    for (t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (pulseOut[ch] && !prev) begin
        rises++;
        if (r1 < 0) r1 = t; else if (r2 < 0) r2 = t;
      end
      if (!pulseOut[ch] && prev && f1 < 0) f1 = t;
      prev = pulseOut[ch];
    end
    hiLen = f1 - r1;
    riseGap = r2 - r1;
  endtask

  initial begin
    logic [15:0] v;
    int rises, hiLen, gap;
    logic [NCH-1:0] seen;

    // R1: reset state
    doReset();
    @(negedge clk);
    check(pulseOut == '0, "R1 outputs after reset", pulseOut, 0);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      check(v == 16'h0, "R1 register after reset", v, 0);
    end

    // R3: control word, only the rate bit is kept
    wr(4'd0, 16'hFFFB); rd(4'd0, v);
    check(v == 16'h0000, "R3 control other bits read 0", v, 0);
    wr(4'd0, 16'h0004); rd(4'd0, v);
    check(v == 16'h0004, "R3 control rate bit", v, 4);

    // R2 R3: indirect access, distinct value sets per channel
    doReset();
    for (int c = 0; c < NCH; c++) begin
      wr(4'd1, 16'(c));
      wr(4'd2, 16'(16'h0100 + c * 7)); wr(4'd3, 16'(16'hA000 + c));
      wr(4'd4, 16'(16'h5000 + c));     wr(4'd5, 16'(16'h0B00 + c));
      wr(4'd6, 16'(16'hFFFF - c));     wr(4'd7, 16'(c * 16'h1111));
      wr(4'd8, 16'(16'h8000 + c));     wr(4'd9, 16'((c * 3) % 4));
    end
    for (int c = NCH - 1; c >= 0; c--) begin
      wr(4'd1, 16'(c));
      rd(4'd1, v); check(v == 16'(c), "R2 channel select readback", v, c);
      rd(4'd2, v); check(v == 16'(16'h0100 + c * 7), "R3 delay low half", v, 16'h0100 + c * 7);
      rd(4'd3, v); check(v == 16'(16'hA000 + c), "R3 delay high half", v, 16'hA000 + c);
      rd(4'd4, v); check(v == 16'(16'h5000 + c), "R3 width low half", v, 16'h5000 + c);
      rd(4'd5, v); check(v == 16'(16'h0B00 + c), "R3 width high half", v, 16'h0B00 + c);
      rd(4'd6, v); check(v == 16'(16'hFFFF - c), "R3 period low half", v, 16'hFFFF - c);
      rd(4'd7, v); check(v == 16'(c * 16'h1111), "R3 period high half", v, c * 16'h1111);
      rd(4'd8, v); check(v == 16'(16'h8000 + c), "R2 pulse count", v, 16'h8000 + c);
      rd(4'd9, v); check(v == 16'((c * 3) % 4), "R2 trigger source", v, (c * 3) % 4);
    end

    // R5 R6 R7 R8 R9 R10: sweep of small parameter sets, all channels together
    doReset();
    modelOn = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < NCH; c++)
        cfgCh(c, (c + r) % 4, (c + 2 * r) % 4, (c + r) % 5, (c * r + c) % 4, (c + r) % 4);
      repeat (3) @(negedge clk);
      fire(4'b0001); repeat (2) @(negedge clk);
      fire(4'b0010); fire(4'b0100);
      repeat (5) @(negedge clk);
      fire(4'b1000);
      repeat (20) @(negedge clk);
      fire(4'b1111);
      repeat (100) @(negedge clk);
      // R9: inhibit window
      inhibit = 1'b1;
      seen = '0;
      fire(4'b1111);
      for (int t = 0; t < 30; t++) begin
        @(negedge clk);
        seen = seen | pulseOut;
      end
      check(seen == '0, "R9 no pulse while inhibited", seen, 0);
      inhibit = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R8: retriggers during a burst; R6 R7 fast timing in clocks
    cfgCh(0, 1, 1, 3, 3, 0);
    fire(4'b0001);
    fork
      measure(0, 90, rises, hiLen, gap);
      begin
        for (int k = 0; k < 6; k++) begin
          repeat (3) @(negedge clk);
          fire(4'b0001);
        end
      end
    join
    check(rises == 3, "R8 pulse count with retriggers", rises, 3);
    check(hiLen == FDIV, "R6 width in clocks", hiLen, FDIV);
    check(gap == 3 * FDIV, "R7 period in clocks", gap, 3 * FDIV);

    // R4: slow tick rate
    modelOn = 1'b0;
    wr(4'd0, 16'h0004);
    cfgCh(1, 0, 2, 5, 2, 1);
    fire(4'b0010);
    measure(1, 600, rises, hiLen, gap);
    check(rises == 2, "R4 slow-rate pulse count", rises, 2);
    check(hiLen == 2 * SDIV, "R4 slow-rate width in clocks", hiLen, 2 * SDIV);
    check(gap == 5 * SDIV, "R4 slow-rate period in clocks", gap, 5 * SDIV);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule